// File: doc/BRIEF.md
# Two-of-seven transition-coded chip link

This block holds both ends of a delay-insensitive link between two chips. The sending end takes bytes, or an end-of-packet request, from a valid/ready port. It sends each byte as two 4-bit symbols, low nibble first. A symbol is one toggle on each of two of seven data wires. Nothing is returned to a rest level between symbols: the information is the change itself. The receiving end compares its synchronised view of the wires with the levels it last accepted. When exactly two wires differ, it decodes the symbol and answers by toggling a single acknowledge wire.

The two ends are driven by separate resets. A side that leaves reset offers a token, so a peer that is waiting for an acknowledge cannot stall. The sending end absorbs any acknowledge toggle that arrives while it has nothing outstanding, so a spare token is harmless. Wire levels change only when both resets are asserted together, so resetting one side alone leaves the lines untouched. The link wires appear as ports: the outgoing data and incoming acknowledge of the sending end, and the incoming data and outgoing acknowledge of the receiving end. A loopback connects them directly.

Top module: `l27_link`

## Requirements
- R1: Each symbol the sending end emits toggles exactly two of the seven `tx_wires` bits and leaves the other five at their previous levels.
- R2: Code index k selects a wire pair, counting pairs (i,j) with i<j in order of i, then j: index 0 is wires 0 and 1, index 6 is wires 1 and 2, index 16 is wires 3 and 5. Nibble value v uses index v. End-of-packet uses index 16. Indices 17 to 20 are unused.
- R3: A byte accepted with `s_eop` low is sent as its low nibble and then its high nibble. A request with `s_eop` high sends only the end-of-packet symbol, and `s_byte` is ignored.
- R4: After sending a symbol, the sending end keeps `tx_wires` stable and `s_ready` low until it sees a transition on `tx_ack_in`.
- R5: When exactly two synchronised receive wires differ from the stored levels and form a used pair, `r_valid` pulses for one cycle. `r_nib` then carries the nibble, or `r_eop` is high for the end-of-packet symbol.
- R6: When more than two wires differ, or two wires form an unused pair, `r_err` pulses for one cycle with `r_valid` low. The stored levels are reloaded, so the next symbol decodes normally.
- R7: The receiving end toggles `rx_ack` exactly once for every symbol it accepts or rejects.
- R8: After `rx_rst_n` is released, the receiving end reloads its stored levels for `SETTLE_CYCLES` cycles. It then toggles `rx_ack` once as its token.
- R9: Asserting `tx_rst_n` alone leaves `tx_wires` unchanged and returns `s_ready` high. An acknowledge transition that arrives while nothing is outstanding causes no wire change.
- R10: After either side alone has been reset, a byte offered afterwards arrives intact, with no deadlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| tx_rst_n | input | 1 | Active-low reset, sending end |
| rx_rst_n | input | 1 | Active-low reset, receiving end |
| s_valid | input | 1 | Request to send a byte or end-of-packet |
| s_ready | output | 1 | Sending end can take a request |
| s_byte | input | 8 | Byte to send |
| s_eop | input | 1 | Send the end-of-packet symbol instead of the byte |
| tx_wires | output | 7 | Outgoing transition-coded data wires |
| tx_ack_in | input | 1 | Acknowledge wire returned to the sending end |
| rx_wires_in | input | 7 | Data wires arriving at the receiving end |
| rx_ack | output | 1 | Acknowledge wire driven by the receiving end |
| r_valid | output | 1 | One-cycle pulse: symbol decoded |
| r_nib | output | 4 | Decoded nibble |
| r_eop | output | 1 | Decoded symbol is end-of-packet |
| r_err | output | 1 | One-cycle pulse: illegal wire change |

## Verification
The bench holds the acknowledge back to show that a sender which ignores it would overrun the receiver with a second toggle. It corrupts the line in two ways: three wires flipped at once, and one of the four unused pairs. A receiver that accepted these or failed to resynchronise would emit false nibbles and then garble the next clean byte. It resets the sending end while a symbol is unacknowledged, and then lets the stale acknowledge through. A sender that treated that acknowledge as a permission would toggle the wires with nothing to send. It resets the receiving end in the middle of a byte. A missing token would leave the sender stuck with `s_ready` low forever.

// File: rtl/l27_pkg.sv
package l27_pkg;

   localparam int LANES   = 7;
   localparam int NIB_W   = 4;
   localparam int NCODE   = LANES * (LANES - 1) / 2;
   localparam int EOP_IDX = 2 ** NIB_W;
   localparam int IDX_W   = $clog2(NCODE + 1);

   typedef logic [LANES-1:0] lane_t;
   typedef logic [NIB_W-1:0] nib_t;

   // pair number idx, pairs ordered by lower wire, then upper wire
   function automatic lane_t pair_code(input int idx);
      lane_t c;
      int    k;
      c = '0;
      k = 0;
      for (int i = 0; i < LANES; i++) begin
         for (int j = i + 1; j < LANES; j++) begin
            if (k == idx) begin
               c[i] = 1'b1;
               c[j] = 1'b1;
            end
            k++;
         end
      end
      return c;
   endfunction

endpackage

// File: rtl/l27_sync.sv
module l27_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("l27_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/l27_tx.sv
module l27_tx
   import l27_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl_rst_n,
   input  logic       s_valid,
   output logic       s_ready,
   input  logic [7:0] s_byte,
   input  logic       s_eop,
   input  logic       ack_in,
   output lane_t      wires
);
   typedef enum logic [1:0] {TX_IDLE, TX_WAIT_HI, TX_WAIT_END} tx_state_t;

   tx_state_t state_q;
   logic      ack_s, ack_ref_q, ack_edge;
   nib_t      hi_q;
   lane_t     lvl_q, code_next;
   logic      fire;

   l27_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(ack_in), .q(ack_s)
   );

   assign ack_edge = (ack_s != ack_ref_q);
   assign s_ready  = rst_n && (state_q == TX_IDLE);

   always_comb begin
      fire      = 1'b0;
      code_next = '0;
      case (state_q)
         TX_IDLE: begin
            fire      = s_valid;
            code_next = s_eop ? pair_code(EOP_IDX) : pair_code(int'(s_byte[3:0]));
         end
         TX_WAIT_HI: begin
            fire      = ack_edge;
            code_next = pair_code(int'(hi_q));
         end
         default: begin
            fire      = 1'b0;
            code_next = '0;
         end
      endcase
   end

   // line levels survive a reset of this side alone
   always_ff @(posedge clk or negedge lvl_rst_n) begin
      if (!lvl_rst_n)           lvl_q <= '0;
      else if (rst_n && fire)   lvl_q <= lvl_q ^ code_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= TX_IDLE;
         ack_ref_q <= 1'b0;
         hi_q      <= '0;
      end else begin
         case (state_q)
            TX_IDLE: begin
               ack_ref_q <= ack_s;          // idle: spare tokens are absorbed
               if (s_valid) begin
                  hi_q    <= s_byte[7:4];
                  state_q <= s_eop ? TX_WAIT_END : TX_WAIT_HI;
               end
            end
            TX_WAIT_HI: begin
               if (ack_edge) begin
                  ack_ref_q <= ack_s;
                  state_q   <= TX_WAIT_END;
               end
            end
            default: begin
               if (ack_edge) begin
                  ack_ref_q <= ack_s;
                  state_q   <= TX_IDLE;
               end
            end
         endcase
      end
   end

   assign wires = lvl_q;

   assert_pair_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q != $past(lvl_q)) |-> ($countones(lvl_q ^ $past(lvl_q)) == 2));

   assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != TX_IDLE && !ack_edge) |=> $stable(lvl_q));

   assert_two_halves_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TX_WAIT_HI) |=> (state_q != TX_IDLE));
endmodule

// File: rtl/l27_rx.sv
module l27_rx
   import l27_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int SETTLE_CYCLES = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  lvl_rst_n,
   input  lane_t wires_in,
   output logic  ack,
   output logic  r_valid,
   output nib_t  r_nib,
   output logic  r_eop,
   output logic  r_err
);
   localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

   typedef enum logic {RX_SETTLE, RX_RUN} rx_state_t;

   rx_state_t        state_q;
   logic [CNT_W-1:0] cnt_q;
   lane_t            ws, ref_q, diff;
   logic [NCODE-1:0] hit;
   int               idx;
   int               nchg;
   logic             ack_q, tog, token;

   l27_sync #(.W(LANES), .STAGES(SYNC_STAGES)) u_wire_sync (
      .clk(clk), .rst_n(rst_n), .d(wires_in), .q(ws)
   );

   assign diff = ws ^ ref_q;
   assign nchg = $countones(diff);

   generate
      for (genvar k = 0; k < NCODE; k++) begin : g_match
         assign hit[k] = (diff == pair_code(k));
      end
   endgenerate

   always_comb begin
      idx = NCODE;
      for (int k = 0; k < NCODE; k++) begin
         if (hit[k]) idx = k;
      end
   end

   assign token = (state_q == RX_SETTLE) && (int'(cnt_q) == SETTLE_CYCLES - 1);
   assign tog   = token || ((state_q == RX_RUN) && (nchg >= 2));

   always_ff @(posedge clk or negedge lvl_rst_n) begin
      if (!lvl_rst_n)        ack_q <= 1'b0;
      else if (rst_n && tog) ack_q <= ~ack_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_SETTLE;
         cnt_q   <= '0;
         ref_q   <= '0;
         r_valid <= 1'b0;
         r_nib   <= '0;
         r_eop   <= 1'b0;
         r_err   <= 1'b0;
      end else begin
         r_valid <= 1'b0;
         r_eop   <= 1'b0;
         r_err   <= 1'b0;
         if (state_q == RX_SETTLE) begin
            ref_q <= ws;
            cnt_q <= cnt_q + 1'b1;
            if (token) state_q <= RX_RUN;
         end else if (nchg >= 2) begin
            ref_q <= ws;
            if (nchg == 2 && idx <= EOP_IDX) begin
               r_valid <= 1'b1;
               r_eop   <= (idx == EOP_IDX);
               r_nib   <= (idx == EOP_IDX) ? '0 : idx[NIB_W-1:0];
            end else begin
               r_err <= 1'b1;
            end
         end
      end
   end

   assign ack = ack_q;

   assert_valid_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(r_valid && r_err));

   assert_ack_per_symbol_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid || r_err) |-> (ack_q != $past(ack_q)));

   assert_eop_is_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      r_eop |-> r_valid);

   assert_quiet_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_SETTLE) |=> !r_valid && !r_err);
endmodule

// File: rtl/l27_link.sv
module l27_link
   import l27_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int SETTLE_CYCLES = 4
) (
   input  logic       clk,
   input  logic       tx_rst_n,
   input  logic       rx_rst_n,
   input  logic       s_valid,
   output logic       s_ready,
   input  logic [7:0] s_byte,
   input  logic       s_eop,
   output logic [6:0] tx_wires,
   input  logic       tx_ack_in,
   input  logic [6:0] rx_wires_in,
   output logic       rx_ack,
   output logic       r_valid,
   output logic [3:0] r_nib,
   output logic       r_eop,
   output logic       r_err
);
   logic lvl_rst_n;

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (SETTLE_CYCLES <= SYNC_STAGES) begin : g_chk_settle
         $error("SETTLE_CYCLES must exceed SYNC_STAGES");
      end
      if (NCODE <= EOP_IDX) begin : g_chk_code
         $error("too few wire pairs for the symbol set");
      end
      if (LANES != 7 || NIB_W != 4) begin : g_chk_ports
         $error("port widths assume seven lanes and 4-bit symbols");
      end
   endgenerate

   // line levels clear only when both sides are held in reset together
   assign lvl_rst_n = tx_rst_n | rx_rst_n;

   l27_tx #(.SYNC_STAGES(SYNC_STAGES)) u_tx (
      .clk(clk), .rst_n(tx_rst_n), .lvl_rst_n(lvl_rst_n),
      .s_valid(s_valid), .s_ready(s_ready), .s_byte(s_byte), .s_eop(s_eop),
      .ack_in(tx_ack_in), .wires(tx_wires)
   );

   l27_rx #(.SYNC_STAGES(SYNC_STAGES), .SETTLE_CYCLES(SETTLE_CYCLES)) u_rx (
      .clk(clk), .rst_n(rx_rst_n), .lvl_rst_n(lvl_rst_n),
      .wires_in(rx_wires_in), .ack(rx_ack),
      .r_valid(r_valid), .r_nib(r_nib), .r_eop(r_eop), .r_err(r_err)
   );
endmodule

// File: tb/sim_l27_link.sv
module sim_l27_link;
   logic       clk = 1'b0;
   logic       tx_rst_n = 1'b0, rx_rst_n = 1'b0;
   logic       s_valid = 1'b0, s_eop = 1'b0;
   logic [7:0] s_byte = '0;
   logic       s_ready;
   logic [6:0] tx_wires, flip = '0;
   logic       rx_ack, hold = 1'b0, held_val = 1'b0;
   logic       r_valid, r_eop, r_err;
   logic [3:0] r_nib;

   int checks = 0, errors = 0, cyc = 0;
   int rx_n = 0, err_n = 0, wchg = 0, bad_w = 0, ack_n = 0;
   logic [4:0] log_sym [256];
   logic [6:0] prev_w = '0;
   logic       prev_a = 1'b0;

   always #2 clk = ~clk;

   l27_link u0 (
      .clk(clk), .tx_rst_n(tx_rst_n), .rx_rst_n(rx_rst_n),
      .s_valid(s_valid), .s_ready(s_ready), .s_byte(s_byte), .s_eop(s_eop),
      .tx_wires(tx_wires), .tx_ack_in(hold ? held_val : rx_ack),
      .rx_wires_in(tx_wires ^ flip), .rx_ack(rx_ack),
      .r_valid(r_valid), .r_nib(r_nib), .r_eop(r_eop), .r_err(r_err)
   );

   // {eop, byte}
   localparam logic [8:0] VEC [7] = '{9'h000, 9'h0FF, 9'h0A5, 9'h03C, 9'h19C, 9'h071, 9'h1FF};

   function automatic logic [6:0] pcode(input int idx);
      logic [6:0] c = '0;
      int k = 0;
      for (int i = 0; i < 7; i++)
         for (int j = i + 1; j < 7; j++) begin
            if (k == idx) begin c[i] = 1'b1; c[j] = 1'b1; end
            k++;
         end
      return c;
   endfunction

   always @(negedge clk) begin
      if (r_valid) begin log_sym[rx_n[7:0]] = {r_eop, r_nib}; rx_n++; end
      if (r_err) err_n++;
      if (tx_wires !== prev_w) begin
         wchg++;
         if ($countones(tx_wires ^ prev_w) != 2) bad_w++;
      end
      if (rx_ack !== prev_a) ack_n++;
      prev_w = tx_wires;
      prev_a = rx_ack;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic step(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b, input logic e);
      s_byte  = b;
      s_eop   = e;
      s_valid = 1'b1;
      while (!s_ready) step();
      step();
      s_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (!s_ready) step();
      step(30);
   endtask

   initial begin
      int base, ab, wb, eb, n_exp;
      logic [4:0] exp_sym [32];
      logic [6:0] w0;

      step(5);
      chk(s_ready == 1'b0 && r_valid == 1'b0, "R9 reset outputs", {s_ready, r_valid}, 0);
      tx_rst_n = 1'b1;
      rx_rst_n = 1'b1;
      step(1);
      chk(s_ready == 1'b1, "R9 ready after reset", s_ready, 1);
      chk(r_valid == 1'b0 && r_err == 1'b0, "R5 quiet after reset", {r_valid, r_err}, 0);
      step(20);
      chk(rx_ack == 1'b1, "R8 token toggle", rx_ack, 1);
      chk(tx_wires == 7'h00, "R9 token absorbed, no wire change", tx_wires, 0);

      // table walk
      n_exp = 0;
      for (int v = 0; v < 7; v++) begin
         if (VEC[v][8]) begin exp_sym[n_exp] = 5'h10; n_exp++; end
         else begin
            exp_sym[n_exp] = {1'b0, VEC[v][3:0]}; n_exp++;
            exp_sym[n_exp] = {1'b0, VEC[v][7:4]}; n_exp++;
         end
      end
      base = rx_n; ab = ack_n; eb = err_n;
      for (int v = 0; v < 7; v++) send(VEC[v][7:0], VEC[v][8]);
      wait_idle();
      chk(rx_n - base == n_exp, "R3 symbol count", rx_n - base, n_exp);
      for (int i = 0; i < n_exp; i++)
         chk(log_sym[base + i] == exp_sym[i], "R3 R5 decoded symbol", log_sym[base + i], exp_sym[i]);
      chk(bad_w == 0, "R1 two-wire toggles", bad_w, 0);
      chk(ack_n - ab == n_exp, "R7 one ack per symbol", ack_n - ab, n_exp);
      chk(err_n == eb, "R6 no error on clean data", err_n - eb, 0);

      // acknowledge held back
      held_val = rx_ack;
      hold = 1'b1;
      w0 = tx_wires;
      wb = wchg;
      base = rx_n;
      send(8'h96, 1'b0);
      step(30);
      chk(tx_wires == (w0 ^ pcode(6)), "R2 wire pair for nibble 6", tx_wires, w0 ^ pcode(6));
      chk(wchg - wb == 1, "R4 one symbol while unacked", wchg - wb, 1);
      chk(s_ready == 1'b0, "R4 not ready while unacked", s_ready, 0);
      chk(rx_n - base == 1 && log_sym[base] == 5'h06, "R5 nibble received", log_sym[base], 6);

      // reset of sending end alone
      tx_rst_n = 1'b0;
      step(3);
      chk(tx_wires == (w0 ^ pcode(6)), "R9 levels kept in reset", tx_wires, w0 ^ pcode(6));
      tx_rst_n = 1'b1;
      step(1);
      chk(s_ready == 1'b1, "R9 ready after own reset", s_ready, 1);
      wb = wchg;
      hold = 1'b0;
      step(30);
      chk(wchg == wb, "R9 stale ack ignored", wchg - wb, 0);
      base = rx_n;
      send(8'h5A, 1'b0);
      wait_idle();
      chk(rx_n - base == 2 && log_sym[base] == 5'h0A && log_sym[base + 1] == 5'h05,
          "R10 byte after sender reset", {log_sym[base], log_sym[base + 1]}, 10'h145);

      // end-of-packet with the byte ignored
      base = rx_n; w0 = tx_wires;
      send(8'h33, 1'b1);
      wait_idle();
      chk(tx_wires == (w0 ^ pcode(16)), "R2 end-of-packet pair", tx_wires, w0 ^ pcode(16));
      chk(rx_n - base == 1 && log_sym[base] == 5'h10, "R3 single end-of-packet", rx_n - base, 1);

      // line corruption
      base = rx_n; eb = err_n; ab = ack_n;
      flip = flip ^ 7'b0000111;
      step(20);
      chk(err_n - eb == 1 && rx_n == base, "R6 three-wire change rejected", err_n - eb, 1);
      flip = flip ^ 7'b1100000;
      step(20);
      chk(err_n - eb == 2 && rx_n == base, "R6 unused pair rejected", err_n - eb, 2);
      chk(ack_n - ab == 2, "R7 ack for rejected symbols", ack_n - ab, 2);
      send(8'h42, 1'b0);
      wait_idle();
      chk(rx_n - base == 2 && log_sym[base] == 5'h02 && log_sym[base + 1] == 5'h04,
          "R6 resync after error", {log_sym[base], log_sym[base + 1]}, 10'h044);

      // reset of receiving end mid-byte
      send(8'hC3, 1'b0);
      step(2);
      rx_rst_n = 1'b0;
      step(3);
      rx_rst_n = 1'b1;
      wait_idle();
      chk(s_ready == 1'b1, "R10 no deadlock after receiver reset", s_ready, 1);
      base = rx_n; eb = err_n;
      send(8'hB7, 1'b0);
      wait_idle();
      chk(rx_n - base == 2 && log_sym[base] == 5'h07 && log_sym[base + 1] == 5'h0B,
          "R10 byte after receiver reset", {log_sym[base], log_sym[base + 1]}, 10'h0EB);
      chk(err_n == eb, "R10 clean after receiver reset", err_n - eb, 0);
      chk(bad_w == 0, "R1 all toggles paired", bad_w, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule